// File: doc/BRIEF.md
# Single-Precision Floating-Point Divider

This block divides one 32-bit binary floating-point value by another and returns the correctly rounded quotient. Both operands are split into sign, biased exponent and a 24-bit significand, with the implicit leading one placed above the 23 stored fraction bits. The significand ratio then comes from a sequential restoring divider that produces one quotient bit per clock. The quotient supplies the result significand and the guard and round bits below it. A nonzero final remainder supplies the sticky bit. The result is normalised, rounded to nearest with ties to even, range-checked and packed.

Operands are offered on a valid/ready input channel. `in_ready` is high only while no operation is pending, so upstream stalls for the whole division. Once the result is ready, it is held on a valid/ready output channel until the consumer takes it. The block accepts no new operands until that output handshake completes. Exponent fields of zero are taken as signed zeros, so subnormals are flushed. Special operands are resolved in the acceptance cycle and do not start the divider.

Top module: `fdiv_sp`

## Requirements
- R1: `in_ready` is 1 exactly when no operation is pending or held. Operands are captured only in a cycle where `in_valid` and `in_ready` are both 1. `in_valid` or operand changes in any other cycle have no effect on the result that is delivered.
- R2: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_result` keeps its value. In the cycle after `out_valid` and `out_ready` are both 1, `out_valid` is 0 and `in_ready` is 1.
- R3: For special operands, `out_valid` is 1 right after the accepting clock edge. Two normal operands have biased exponent fields in 1..254. For them, `out_valid` first becomes 1 after the 27th rising edge that follows the accepting edge, since the divider produces one quotient bit per clock.
- R4: For every non-NaN result, bit 31 equals the XOR of the operand sign bits (bit 31).
- R5: For normal operands, the significand is `1.fraction` (fraction in bits 22:0). The result significand is the quotient rounded to nearest-even. The two quotient bits below the LSB are guard and round, and sticky is 1 when the final remainder is nonzero. An example is 1/3 = 0x3EAAAAAB.
- R6: The biased result exponent (bits 30:23) is dividend exponent minus divisor exponent plus 127. It is one lower when the dividend significand is smaller than the divisor significand.
- R7: Any NaN operand (exponent 255, fraction nonzero), 0/0 or inf/inf yields exactly 0x7FC00000.
- R8: A nonzero dividend over a zero divisor, or an infinite dividend (exponent 255, fraction 0) over a non-NaN, non-infinite divisor, yields a signed infinity: exponent 255, fraction 0.
- R9: A zero dividend over a nonzero non-NaN divisor, or a finite dividend over an infinite divisor, yields a signed zero. Any operand whose exponent field is 0 counts as zero.
- R10: A rounded biased exponent of 255 or more gives a signed infinity. One of 0 or less gives a signed zero. A result exponent of exactly 1 or 254 is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block idle and able to take an operand pair |
| in_a | input | 32 | Dividend, single-precision |
| in_b | input | 32 | Divisor, single-precision |
| out_valid | output | 1 | Result available and held |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Rounded quotient, single-precision |

## Verification
The assertions assume that reset is applied before the first operation. They also assume that `in_a` and `in_b` carry meaningful data in any cycle where `in_valid` meets `in_ready`. The checker tells normal operands from special ones only through the exponent fields, so the latency and sign properties rest on the same classification as R3. The stimulus changes inputs only on the falling clock edge. It offers operands only while the block is idle, except in one deliberate busy-period test. It holds `out_ready` low for a stretch in one test, so that the stability properties see real back-pressure.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

  localparam int EXP_W   = 8;
  localparam int FRAC_W  = 23;
  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int SIG_W   = FRAC_W + 1;          // hidden one restored
  localparam int QUO_W   = SIG_W + 3;           // quotient bits produced
  localparam int DIV_W   = 2 * SIG_W + 3;       // remainder + quotient register
  localparam int XE_W    = EXP_W + 2;           // signed working exponent
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_MAX = (1 << EXP_W) - 1;

  localparam logic [WORD_W-1:0] QNAN_WORD =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef enum logic [1:0] {
    CLS_ZERO,
    CLS_NORM,
    CLS_INF,
    CLS_NAN
  } fclass_e;

  typedef struct packed {
    logic               sign;
    fclass_e            cls;
    logic [EXP_W-1:0]   exp;
    logic [SIG_W-1:0]   sig;
  } operand_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_HOLD
  } fsm_e;

  function automatic operand_t split_word(input logic [WORD_W-1:0] w);
    operand_t o;
    o.sign = w[WORD_W-1];
    o.exp  = w[WORD_W-2 -: EXP_W];
    if (o.exp == '0) begin
      o.cls = CLS_ZERO;
      o.sig = '0;
    end else if (o.exp == {EXP_W{1'b1}}) begin
      o.cls = (w[FRAC_W-1:0] != '0) ? CLS_NAN : CLS_INF;
      o.sig = {1'b1, w[FRAC_W-1:0]};
    end else begin
      o.cls = CLS_NORM;
      o.sig = {1'b1, w[FRAC_W-1:0]};
    end
    return o;
  endfunction

  function automatic logic [WORD_W-1:0] signed_inf(input logic s);
    return {s, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  endfunction

  function automatic logic [WORD_W-1:0] signed_zero(input logic s);
    return {s, {(WORD_W-1){1'b0}}};
  endfunction

endpackage

// File: rtl/fdiv_front.sv
module fdiv_front
  import fdiv_pkg::*;
#(
  parameter int N_OPS = 2
) (
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output operand_t          op_a_o,
  output operand_t          op_b_o,
  output logic              special_o,
  output logic [WORD_W-1:0] special_word_o
);

  logic [WORD_W-1:0] raw [N_OPS];
  operand_t          ops [N_OPS];

  assign raw[0] = a_i;
  assign raw[1] = b_i;

  generate
    for (genvar g = 0; g < N_OPS; g++) begin : g_split
      assign ops[g] = split_word(raw[g]);
    end
  endgenerate

  assign op_a_o = ops[0];
  assign op_b_o = ops[1];

  logic res_sign;
  logic any_nan, zero_zero, inf_inf;

  assign res_sign  = ops[0].sign ^ ops[1].sign;
  assign any_nan   = (ops[0].cls == CLS_NAN) || (ops[1].cls == CLS_NAN);
  assign zero_zero = (ops[0].cls == CLS_ZERO) && (ops[1].cls == CLS_ZERO);
  assign inf_inf   = (ops[0].cls == CLS_INF) && (ops[1].cls == CLS_INF);

  assign special_o = (ops[0].cls != CLS_NORM) || (ops[1].cls != CLS_NORM);

  // Priority: invalid forms first, then infinite results, then zeros.
  always_comb begin
    if (any_nan || zero_zero || inf_inf) begin
      special_word_o = QNAN_WORD;
    end else if (ops[0].cls == CLS_INF || ops[1].cls == CLS_ZERO) begin
      special_word_o = signed_inf(res_sign);
    end else if (ops[0].cls == CLS_ZERO || ops[1].cls == CLS_INF) begin
      special_word_o = signed_zero(res_sign);
    end else begin
      special_word_o = '0;
    end
  end

endmodule

// File: rtl/fdiv_core.sv
module fdiv_core #(
  parameter int SIG_W = 24,
  parameter int QUO_W = SIG_W + 3,
  parameter int DIV_W = 2 * SIG_W + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [SIG_W-1:0] a_sig_i,
  input  logic [SIG_W-1:0] b_sig_i,
  output logic             done_o,
  output logic [QUO_W-1:0] quo_o,
  output logic             rem_nz_o
);

  localparam int CNT_W  = $clog2(QUO_W);
  localparam int STEPS  = QUO_W - 1;   // bits after the one formed at load
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

  // work_q = {partial remainder, quotient bits}
  logic [DIV_W-1:0] work_q;
  logic [SIG_W-1:0] dvsr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             done_q;

  logic [SIG_W:0]   trial;
  logic [SIG_W-1:0] dvsr_sel;
  logic [SIG_W+1:0] diff;
  logic             fits;
  logic [SIG_W-1:0] rem_next;

  // One shared subtractor: the load cycle compares the raw dividend,
  // later cycles compare the doubled remainder.
  assign trial    = start_i ? {1'b0, a_sig_i} : {work_q[DIV_W-1 -: SIG_W], 1'b0};
  assign dvsr_sel = start_i ? b_sig_i : dvsr_q;
  assign diff     = {1'b0, trial} - {2'b00, dvsr_sel};
  assign fits     = ~diff[SIG_W+1];
  assign rem_next = fits ? diff[SIG_W-1:0] : trial[SIG_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q <= '0;
      dvsr_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        work_q <= {rem_next, {(QUO_W-1){1'b0}}, fits};
        dvsr_q <= b_sig_i;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        work_q <= {rem_next, work_q[QUO_W-2:0], fits};
        cnt_q  <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o   = done_q;
  assign quo_o    = work_q[QUO_W-1:0];
  assign rem_nz_o = |work_q[DIV_W-1 -: SIG_W];

endmodule

// File: rtl/fdiv_round.sv
module fdiv_round
  import fdiv_pkg::*;
(
  input  logic [QUO_W-1:0]       quo_i,
  input  logic                   rem_nz_i,
  input  logic signed [XE_W-1:0] exp_i,
  input  logic                   sign_i,
  output logic [WORD_W-1:0]      word_o
);

  localparam logic signed [XE_W-1:0] ONE_X = XE_W'(1);
  localparam logic signed [XE_W-1:0] ZER_X = '0;
  localparam logic signed [XE_W-1:0] TOP_X = XE_W'(EXP_MAX);

  logic [SIG_W-1:0]       sig_t;
  logic                   g_bit, r_bit, s_bit, bump;
  logic [SIG_W:0]         sum;
  logic [SIG_W-1:0]       sig_r;
  logic signed [XE_W-1:0] e_norm, e_fin;

  always_comb begin
    // Quotient lies in (0.5, 2): pick the window by its top bit.
    if (quo_i[QUO_W-1]) begin
      sig_t  = quo_i[QUO_W-1 -: SIG_W];
      g_bit  = quo_i[2];
      r_bit  = quo_i[1];
      s_bit  = quo_i[0] | rem_nz_i;
      e_norm = exp_i;
    end else begin
      sig_t  = quo_i[QUO_W-2 -: SIG_W];
      g_bit  = quo_i[1];
      r_bit  = quo_i[0];
      s_bit  = rem_nz_i;
      e_norm = exp_i - ONE_X;
    end

    bump = g_bit & (r_bit | s_bit | sig_t[0]);
    sum  = {1'b0, sig_t} + {{SIG_W{1'b0}}, bump};
    if (sum[SIG_W]) begin
      sig_r = sum[SIG_W:1];
      e_fin = e_norm + ONE_X;
    end else begin
      sig_r = sum[SIG_W-1:0];
      e_fin = e_norm;
    end

    if (e_fin >= TOP_X) begin
      word_o = signed_inf(sign_i);
    end else if (e_fin <= ZER_X) begin
      word_o = signed_zero(sign_i);
    end else begin
      word_o = {sign_i, e_fin[EXP_W-1:0], sig_r[FRAC_W-1:0]};
    end
  end

endmodule

// File: rtl/fdiv_sp.sv
module fdiv_sp
  import fdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_result
);

  localparam logic signed [XE_W-1:0] BIAS_X = XE_W'(BIAS);

  operand_t               op_a, op_b;
  logic                   spec_hit;
  logic [WORD_W-1:0]      spec_word;
  fsm_e                   state_q;
  logic [WORD_W-1:0]      result_q;
  logic                   sign_q;
  logic signed [XE_W-1:0] exp_q, exp_diff;
  logic                   accept, core_start, core_done, rem_nz;
  logic [QUO_W-1:0]       quo;
  logic [WORD_W-1:0]      round_word;

  fdiv_front u_front (
    .a_i            (in_a),
    .b_i            (in_b),
    .op_a_o         (op_a),
    .op_b_o         (op_b),
    .special_o      (spec_hit),
    .special_word_o (spec_word)
  );

  assign accept     = in_valid && (state_q == ST_IDLE);
  assign core_start = accept && !spec_hit;
  assign exp_diff   = $signed({2'b00, op_a.exp}) - $signed({2'b00, op_b.exp}) + BIAS_X;

  fdiv_core #(
    .SIG_W (SIG_W),
    .QUO_W (QUO_W),
    .DIV_W (DIV_W)
  ) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (core_start),
    .a_sig_i  (op_a.sig),
    .b_sig_i  (op_b.sig),
    .done_o   (core_done),
    .quo_o    (quo),
    .rem_nz_o (rem_nz)
  );

  fdiv_round u_round (
    .quo_i    (quo),
    .rem_nz_i (rem_nz),
    .exp_i    (exp_q),
    .sign_i   (sign_q),
    .word_o   (round_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      result_q <= '0;
      sign_q   <= 1'b0;
      exp_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            sign_q <= op_a.sign ^ op_b.sign;
            exp_q  <= exp_diff;
            if (spec_hit) begin
              result_q <= spec_word;
              state_q  <= ST_HOLD;
            end else begin
              state_q  <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (core_done) begin
            result_q <= round_word;
            state_q  <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (out_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready   = (state_q == ST_IDLE);
  assign out_valid  = (state_q == ST_HOLD);
  assign out_result = result_q;

endmodule

// File: rtl/fdiv_sp_chk.sv
module fdiv_sp_chk
  import fdiv_pkg::*;
#(
  parameter int LAT = QUO_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [WORD_W-1:0] in_a,
  input logic [WORD_W-1:0] in_b,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_result
);

  localparam int CW = $clog2(LAT + 1);

  function automatic logic is_normal(input logic [WORD_W-1:0] w);
    return (w[WORD_W-2 -: EXP_W] != '0) && (w[WORD_W-2 -: EXP_W] != {EXP_W{1'b1}});
  endfunction

  function automatic logic gives_nan(input logic [WORD_W-1:0] a, input logic [WORD_W-1:0] b);
    operand_t x, y;
    x = split_word(a);
    y = split_word(b);
    return (x.cls == CLS_NAN) || (y.cls == CLS_NAN) ||
           (x.cls == CLS_ZERO && y.cls == CLS_ZERO) ||
           (x.cls == CLS_INF && y.cls == CLS_INF);
  endfunction

  logic              acc;
  logic [CW-1:0]     cnt_q;
  logic              nan_q;
  logic              sgn_q;

  assign acc = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      nan_q <= 1'b0;
      sgn_q <= 1'b0;
    end else begin
      if (acc) begin
        nan_q <= gives_nan(in_a, in_b);
        sgn_q <= in_a[WORD_W-1] ^ in_b[WORD_W-1];
      end
      if (acc && is_normal(in_a) && is_normal(in_b)) cnt_q <= CW'(1);
      else if (cnt_q == CW'(LAT))                    cnt_q <= '0;
      else if (cnt_q != '0)                          cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !in_ready);

  assert_not_ready_holding_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));

  assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (in_ready && !out_valid));

  assert_special_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !(is_normal(in_a) && is_normal(in_b))) |=> out_valid);

  assert_no_early_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> !out_valid);

  assert_result_on_time_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(LAT)) |=> out_valid);

  assert_sign_xor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !nan_q) |-> (out_result[WORD_W-1] == sgn_q));

  assert_canonical_nan_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && nan_q) |-> (out_result == QNAN_WORD));

endmodule

bind fdiv_sp fdiv_sp_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_a       (in_a),
  .in_b       (in_b),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result)
);

// File: tb/fdiv_sp_tb.sv
`timescale 1ns/1ps
module fdiv_sp_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_result;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;   // 250 MHz

  fdiv_sp dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_a       (in_a),
    .in_b       (in_b),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_result (out_result)
  );

  // {requirement, dividend, divisor, expected}
  localparam int NV = 33;
  localparam logic [103:0] VEC [NV] = '{
    {8'd5,  32'h40C00000, 32'h40000000, 32'h40400000},  // R5 6/2
    {8'd5,  32'h3F800000, 32'h40400000, 32'h3EAAAAAB},  // R5 1/3 sticky
    {8'd5,  32'h40000000, 32'h40400000, 32'h3F2AAAAB},  // R5 2/3
    {8'd5,  32'h3F800000, 32'h41200000, 32'h3DCCCCCD},  // R5 1/10
    {8'd5,  32'h3F800000, 32'h40E00000, 32'h3E124925},  // R5 1/7
    {8'd6,  32'h3F800000, 32'h3F800000, 32'h3F800000},  // R6 1/1
    {8'd6,  32'h41200000, 32'h40800000, 32'h40200000},  // R6 10/4
    {8'd6,  32'h3FC00000, 32'h3FE00000, 32'h3F5B6DB7},  // R6 1.5/1.75
    {8'd6,  32'h3FFFFFFF, 32'h3F7FFFFF, 32'h40000000},  // R6 equal sigs
    {8'd4,  32'hC0F00000, 32'h40200000, 32'hC0400000},  // R4 -7.5/2.5
    {8'd4,  32'h40400000, 32'hC0000000, 32'hBFC00000},  // R4 3/-2
    {8'd10, 32'h7F000000, 32'h3F000000, 32'h7F800000},  // R10 overflow
    {8'd10, 32'hFF000000, 32'h3F000000, 32'hFF800000},  // R10 neg overflow
    {8'd10, 32'h00800000, 32'h40000000, 32'h00000000},  // R10 underflow
    {8'd10, 32'h00800000, 32'hC0000000, 32'h80000000},  // R10 neg underflow
    {8'd10, 32'h00800000, 32'h3F800000, 32'h00800000},  // R10 exp 1 kept
    {8'd10, 32'h7F000000, 32'h3F800000, 32'h7F000000},  // R10 exp 254 kept
    {8'd7,  32'h7FC00000, 32'h3F800000, 32'h7FC00000},  // R7 nan/x
    {8'd7,  32'h3F800000, 32'h7F800001, 32'h7FC00000},  // R7 x/snan
    {8'd7,  32'h00000000, 32'h80000000, 32'h7FC00000},  // R7 0/0
    {8'd7,  32'h7F800000, 32'hFF800000, 32'h7FC00000},  // R7 inf/inf
    {8'd7,  32'hFFC00000, 32'h3F800000, 32'h7FC00000},  // R7 neg nan
    {8'd8,  32'h3F800000, 32'h00000000, 32'h7F800000},  // R8 1/0
    {8'd8,  32'hBF800000, 32'h00000000, 32'hFF800000},  // R8 -1/0
    {8'd8,  32'h3F800000, 32'h80000000, 32'hFF800000},  // R8 1/-0
    {8'd8,  32'h7F800000, 32'h40000000, 32'h7F800000},  // R8 inf/2
    {8'd8,  32'hFF800000, 32'h40000000, 32'hFF800000},  // R8 -inf/2
    {8'd8,  32'h3F800000, 32'h00400000, 32'h7F800000},  // R8 flushed divisor
    {8'd9,  32'h00000000, 32'h40A00000, 32'h00000000},  // R9 0/5
    {8'd9,  32'h80000000, 32'h40A00000, 32'h80000000},  // R9 -0/5
    {8'd9,  32'h40400000, 32'h7F800000, 32'h00000000},  // R9 3/inf
    {8'd9,  32'h40400000, 32'hFF800000, 32'h80000000},  // R9 3/-inf
    {8'd9,  32'h00400000, 32'h3F800000, 32'h00000000}   // R9 flushed dividend
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                        output logic [31:0] res, output int lat);
    @(negedge clk);
    in_a = a; in_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    while (!out_valid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    res = out_result;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  function automatic logic normal_word(input logic [31:0] w);
    return (w[30:23] != 8'h00) && (w[30:23] != 8'hFF);
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R3 watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] res;
    int          lat;
    int          stray;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state: ready, nothing held
    check("R1 reset", {30'd0, in_ready, out_valid}, 32'd2);

    for (int i = 0; i < NV; i++) begin : vec_loop
      logic [7:0]  req;
      logic [31:0] va, vb, ve;
      int          lexp;
      {req, va, vb, ve} = VEC[i];
      lexp = (normal_word(va) && normal_word(vb)) ? 27 : 0;
      run_op(va, vb, res, lat);
      check($sformatf("R%0d vector %0d", req, i), res, ve);
      check($sformatf("R3 latency vector %0d", i), lat, lexp);
    end

    // R1: offers during a busy division are ignored
    @(negedge clk);
    in_a = 32'h3F800000; in_b = 32'h40400000; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    in_a = 32'h40C00000; in_b = 32'h40000000; in_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R1 busy not ready", {31'd0, in_ready}, 32'd0);
    end
    in_valid = 1'b0;
    lat = 0;
    while (!out_valid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    check("R1 busy offer ignored", out_result, 32'h3EAAAAAB);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    stray = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (out_valid) stray++;
    end
    check("R1 no second result", stray, 0);

    // R2: back-pressure holds the result
    @(negedge clk);
    in_a = 32'h41200000; in_b = 32'h40800000; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    while (!out_valid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check("R2 held valid", {31'd0, out_valid}, 32'd1);
      check("R2 held result", out_result, 32'h40200000);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check("R2 released", {30'd0, in_ready, out_valid}, 32'd2);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule